// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of semaphore latches that two requesters, a left port and a right port, use to claim shared resources. The latches are kept apart from any memory array. A port reaches them through a semaphore select, a read/write strobe, an address and a data bus. The low address bits pick one latch.

A write looks only at data bit 0. A 0 asks for the latch and a 1 gives it up, or withdraws a request that is still waiting. Each latch shows the two ports complementary views: the owner reads 0 and the other side reads 1. A request from the side that does not own the latch is queued. When the owner releases, ownership passes to the queued side with no further write. A read copies the requesting port's view onto every bit of its read bus.

Each latch is a small state machine with five states:
- FREE: no owner, and both ports read 1.
- OWN_L: the left port owns the latch.
- OWN_R: the right port owns the latch.
- OWN_L_PR: the left port owns the latch and a right request is waiting.
- OWN_R_PL: the right port owns the latch and a left request is waiting.

The transitions are named as follows:
- grant: FREE to OWN_L or OWN_R.
- tie: FREE to OWN_L_PR, when both ports request in the same cycle.
- queue: OWN_L to OWN_L_PR, or OWN_R to OWN_R_PL.
- free: OWN_L or OWN_R back to FREE.
- handoff: OWN_L_PR to OWN_R, or OWN_R_PL to OWN_L.
- cancel: OWN_L_PR to OWN_L, or OWN_R_PL to OWN_R.
- release-with-cancel: OWN_L_PR or OWN_R_PL to FREE, when the owner releases and the waiting side withdraws in the same cycle.

Top module: `sem_bank_top`

## Requirements
- R1: There are eight latches, and the latch is chosen by addr[2:0]. The higher address bits have no effect.
- R2: An access counts only when sem_sel is 1 and mem_en is 0. Any other combination changes no latch and leaves rdata holding its value.
- R3: A write uses only wdata[0]. A 0 is a request and a 1 is a release or a cancel. All other wdata bits are ignored.
- R4: When a port requests a FREE latch, that port reads 0 from it and the other port reads 1.
- R5: While a latch is owned, a request from the other port does not take ownership. The owner keeps the latch until it writes 1.
- R6: When the owner writes 1 and no request is waiting, both ports read 1. When a request is waiting, the waiting port owns the latch from the next cycle and reads 0.
- R7: A read puts the port's view (0 = owned by this port, 1 = not) on all DATA_W bits of rdata, one clock edge after the strobe. The value is the latch state before any write made at that same edge.
- R8: If both ports request the same FREE latch in the same cycle, the left port wins and the right request is queued.
- R9: A non-owner writing 1 withdraws its own waiting request and does not disturb the owner.
- R10: After reset every latch is FREE, and both rdata buses are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sem_sel | input | 1 | Left semaphore select, active high |
| l_mem_en | input | 1 | Left memory enable; must be 0 for a semaphore access |
| l_wr | input | 1 | Left strobe: 1 write, 0 read |
| l_addr | input | ADDR_W (15) | Left address; bits [2:0] pick the latch |
| l_wdata | input | DATA_W (16) | Left write data; bit 0 only |
| l_rdata | output | DATA_W (16) | Left read data, registered |
| r_sem_sel | input | 1 | Right semaphore select, active high |
| r_mem_en | input | 1 | Right memory enable; must be 0 for a semaphore access |
| r_wr | input | 1 | Right strobe: 1 write, 0 read |
| r_addr | input | ADDR_W (15) | Right address; bits [2:0] pick the latch |
| r_wdata | input | DATA_W (16) | Right write data; bit 0 only |
| r_rdata | output | DATA_W (16) | Right read data, registered |

## Verification
A write presented before rising edge N changes the latch state at edge N. A read strobe presented before edge N+1 loads rdata at that edge. The read returns the state after edge N but not the effect of any write made at edge N+1. The bench drives every input on the falling edge, holds it through one rising edge, and compares rdata at the next falling edge, so every value it checks is one register stage after its strobe. One check deliberately reads on the same edge as the owner's release, to confirm that the value returned is the state from before that release.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic [2:0] {
        SEM_FREE,
        SEM_OWN_L,
        SEM_OWN_R,
        SEM_OWN_L_PR,
        SEM_OWN_R_PL
    } sem_state_e;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 16,
    parameter int NUM_SEM = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               sem_sel,
    input  logic               mem_en,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               rd_hit,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_SEM-1:0] req_vec,
    output logic [NUM_SEM-1:0] rel_vec
);
    logic access;
    logic unused_bits;

    // Only the low index bits and wdata[0] carry meaning
    assign unused_bits = &{1'b0, addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};
    assign access = sem_sel && !mem_en;
    assign idx    = addr[IDX_W-1:0];
    assign rd_hit = access && !wr;

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
        assign req_vec[g] = access && wr && (idx == IDX_W'(g)) && !wdata[0];
        assign rel_vec[g] = access && wr && (idx == IDX_W'(g)) &&  wdata[0];
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic l_view,
    output logic r_view
);
    sem_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEM_FREE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SEM_FREE: begin
                if (l_req)      nxt = r_req ? SEM_OWN_L_PR : SEM_OWN_L;
                else if (r_req) nxt = SEM_OWN_R;
            end
            SEM_OWN_L: begin
                if (l_rel)      nxt = r_req ? SEM_OWN_R : SEM_FREE;
                else if (r_req) nxt = SEM_OWN_L_PR;
            end
            SEM_OWN_R: begin
                if (r_rel)      nxt = l_req ? SEM_OWN_L : SEM_FREE;
                else if (l_req) nxt = SEM_OWN_R_PL;
            end
            SEM_OWN_L_PR: begin
                if (l_rel)      nxt = r_rel ? SEM_FREE : SEM_OWN_R;
                else if (r_rel) nxt = SEM_OWN_L;
            end
            SEM_OWN_R_PL: begin
                if (r_rel)      nxt = l_rel ? SEM_FREE : SEM_OWN_L;
                else if (l_rel) nxt = SEM_OWN_R;
            end
            default: nxt = SEM_FREE;
        endcase
    end

    always_comb begin
        l_view = 1'b1;
        r_view = 1'b1;
        unique case (state)
            SEM_OWN_L, SEM_OWN_L_PR: l_view = 1'b0;
            SEM_OWN_R, SEM_OWN_R_PL: r_view = 1'b0;
            default: ;
        endcase
    end

    // R4
    free_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEM_FREE && l_req) |=> (!l_view && r_view));
    // R5
    l_owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_view && !l_rel) |=> !l_view);
    // R5
    r_owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_view && !r_rel) |=> !r_view);
    // R6
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEM_OWN_L_PR && l_rel && !r_rel) |=> (!r_view && l_view));
    // R8
    tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEM_FREE && l_req && r_req) |=> (state == SEM_OWN_L_PR));
    // R9
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEM_OWN_L_PR && r_rel && !l_rel) |=> (state == SEM_OWN_L));
endmodule

// File: rtl/sem_readout.sv
module sem_readout #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_hit,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SEM-1:0] views,
    output logic [DATA_W-1:0]  rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '1;
        else if (rd_hit) rdata <= {DATA_W{views[idx]}};
    end

    // R7
    replicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> (rdata == '0 || rdata == '1));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> $stable(rdata));
endmodule

// File: rtl/sem_bank_top.sv
module sem_bank_top #(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 16,
    parameter int NUM_SEM = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sem_sel,
    input  logic              l_mem_en,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sem_sel,
    input  logic              r_mem_en,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    logic               l_rd, r_rd;
    logic [IDX_W-1:0]   l_idx, r_idx;
    logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
    logic [NUM_SEM-1:0] l_views, r_views;

    sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_dec_l (
        .sem_sel(l_sem_sel), .mem_en(l_mem_en), .wr(l_wr), .addr(l_addr),
        .wdata(l_wdata), .rd_hit(l_rd), .idx(l_idx), .req_vec(l_req), .rel_vec(l_rel));

    sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_dec_r (
        .sem_sel(r_sem_sel), .mem_en(r_mem_en), .wr(r_wr), .addr(r_addr),
        .wdata(r_wdata), .rd_hit(r_rd), .idx(r_idx), .req_vec(r_req), .rel_vec(r_rel));

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[g]), .l_rel(l_rel[g]),
            .r_req(r_req[g]), .r_rel(r_rel[g]),
            .l_view(l_views[g]), .r_view(r_views[g]));
    end

    sem_readout #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_hit(l_rd), .idx(l_idx),
        .views(l_views), .rdata(l_rdata));

    sem_readout #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_hit(r_rd), .idx(r_idx),
        .views(r_views), .rdata(r_rdata));
endmodule

// File: tb/sim_sem_bank_top.sv
module sim_sem_bank_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l_sem_sel = 0, l_mem_en = 0, l_wr = 0;
    logic [14:0] l_addr = '0;
    logic [15:0] l_wdata = '0;
    logic [15:0] l_rdata;
    logic        r_sem_sel = 0, r_mem_en = 0, r_wr = 0;
    logic [14:0] r_addr = '0;
    logic [15:0] r_wdata = '0;
    logic [15:0] r_rdata;
    int          nchk = 0;
    int          nerr = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    sem_bank_top u0 (
        .clk(clk), .rst_n(rst_n),
        .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_wr(l_wr),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_wr(r_wr),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata));

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        l_sem_sel = 0; l_mem_en = 0; l_wr = 0; l_wdata = '0;
        r_sem_sel = 0; r_mem_en = 0; r_wr = 0; r_wdata = '0;
    endtask

    task automatic l_set(input logic wr, input logic [14:0] a, input logic [15:0] d);
        l_sem_sel = 1; l_wr = wr; l_addr = a; l_wdata = d;
    endtask

    task automatic r_set(input logic wr, input logic [14:0] a, input logic [15:0] d);
        r_sem_sel = 1; r_wr = wr; r_addr = a; r_wdata = d;
    endtask

    task automatic l_write(input logic [14:0] a, input logic [15:0] d);
        l_set(1, a, d); cycle(); idle();
    endtask

    task automatic r_write(input logic [14:0] a, input logic [15:0] d);
        r_set(1, a, d); cycle(); idle();
    endtask

    task automatic both_read(input logic [14:0] a, input logic el, input logic er, input string tag);
        l_set(0, a, '0); r_set(0, a, '0); cycle(); idle();
        check({tag, " left"},  l_rdata, {16{el}});
        check({tag, " right"}, r_rdata, {16{er}});
    endtask

    task automatic t_reset();
        check("R10 left rdata after reset", l_rdata, 16'hFFFF);
        check("R10 right rdata after reset", r_rdata, 16'hFFFF);
        for (int i = 0; i < 8; i++) both_read(15'(i), 1, 1, "R10 free after reset");
    endtask

    task automatic t_grant();
        l_write(15'h7FF2, 16'h0000);
        both_read(15'h0002, 0, 1, "R4 R1 grant via high addr");
        both_read(15'h000A, 0, 1, "R1 alias upper bits");
        both_read(15'h0003, 1, 1, "R1 neighbour untouched");
    endtask

    task automatic t_queue_handoff();
        r_write(15'h0002, 16'h0000);
        both_read(15'h0002, 0, 1, "R5 queued request no take");
        l_write(15'h0002, 16'h0000);
        both_read(15'h0002, 0, 1, "R5 owner rerequest no change");
        // release on same edge as a right read: read shows state before release
        l_set(1, 15'h0002, 16'h0001); r_set(0, 15'h0002, '0); cycle(); idle();
        check("R7 same-edge read sees prior state", r_rdata, 16'hFFFF);
        both_read(15'h0002, 1, 0, "R6 handoff to waiting port");
        r_write(15'h0002, 16'h0001);
        both_read(15'h0002, 1, 1, "R6 release to free");
    endtask

    task automatic t_bit0();
        l_write(15'h0004, 16'hFFFE);
        both_read(15'h0004, 0, 1, "R3 bit0 zero requests");
        l_write(15'h0004, 16'h0001);
        both_read(15'h0004, 1, 1, "R3 bit0 one releases");
    endtask

    task automatic t_gating();
        l_set(1, 15'h0001, 16'h0000); l_mem_en = 1; cycle(); idle();
        both_read(15'h0001, 1, 1, "R2 write ignored with mem_en");
        l_set(1, 15'h0001, 16'h0000); l_sem_sel = 0; cycle(); idle();
        both_read(15'h0001, 1, 1, "R2 write ignored without select");
        l_write(15'h0001, 16'h0000);
        l_set(0, 15'h0001, '0); l_mem_en = 1; cycle(); idle();
        check("R2 read ignored rdata held", l_rdata, 16'hFFFF);
        both_read(15'h0001, 0, 1, "R2 state after valid write");
        l_write(15'h0001, 16'h0001);
    endtask

    task automatic t_tie();
        l_set(1, 15'h0005, 16'h0000); r_set(1, 15'h0005, 16'h0000); cycle(); idle();
        both_read(15'h0005, 0, 1, "R8 left wins tie");
        l_write(15'h0005, 16'h0001);
        both_read(15'h0005, 1, 0, "R8 right queued then owns");
        r_write(15'h0005, 16'h0001);
        both_read(15'h0005, 1, 1, "R8 cleanup free");
    endtask

    task automatic t_cancel();
        r_write(15'h0006, 16'h0000);
        l_write(15'h0006, 16'h0000);
        l_write(15'h0006, 16'h0001);
        both_read(15'h0006, 1, 0, "R9 left cancelled owner kept");
        r_write(15'h0006, 16'h0001);
        both_read(15'h0006, 1, 1, "R9 no handoff after cancel");
        r_write(15'h0006, 16'h0000);
        l_write(15'h0006, 16'h0001);
        both_read(15'h0006, 1, 0, "R5 non-owner release ignored");
        r_write(15'h0006, 16'h0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_grant();
        t_queue_handoff();
        t_bit0();
        t_gating();
        t_tie();
        t_cancel();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule